// File: doc/BRIEF.md
# Parity-Protected Register Error Monitor

This block holds a small bank of processor state registers. Each register carries one even-parity bit. The block decides, for each register, when a parity mismatch counts as a reported error and how the error is classified. It also decides which kind of write removes the error indication. General integer and floating-point registers are checked only when an instruction reads them. Core control registers are checked every cycle. Two trap-setup registers are checked only outside the reset/recovery mode, and an error on either of them raises a fatal error state. The interrupt-level register is checked while interrupts are enabled or when it is accessed. The register-window counters are checked every cycle. The trap-type register has no parity and never reports.

The surrounding pipeline uses a read port and a normal write port. The normal write port has a full/partial strobe and a firmware qualifier. The trap hardware uses a separate full-write port. A soft-error port flips one stored data bit, which models an upset. The outputs are one sticky error flag per register, the summary class lines, and a priority-encoded class code.

Top module: `parity_reg_monitor`

## Requirements
- R1: Parity is even over all DATA_W data bits. A full write stores new data and fresh parity. A partial write (wrFull=0) replaces only the low DATA_W/2 bits and updates parity incrementally, so an existing corruption stays detectable. rdData is combinational from the register selected by rdAddr.
- R2: Addresses 0..NUM_GR-1 are integer registers and NUM_GR..NUM_GR+NUM_FR-1 are floating-point registers. Their mismatch sets the register's flag at the clock edge of an access (rdEn with a matching rdAddr) and never without one. intUrgent is the OR of the integer flags and fpUrgent is the OR of the floating-point flags.
- R3: An integer or floating-point flag is cleared by a normal full write to that register. A partial write leaves the flag set.
- R4: The state registers follow the general registers at offsets 0 (program counter), 1 (next counter) and 2 (state word). They are checked every cycle and raise stateUrgent. Only a trap-port write clears their flag; a normal full write does not.
- R5: Offsets 3 (trap base) and 4 (trap level) are checked only while redMode=0. A detection sets their flag and sets fatalState. The flag clears only on a normal full write with fwMode=1. fatalState stays set until reset.
- R6: Offset 5 (interrupt level) is checked while intEnable=1 or when it is accessed. It raises stateUrgent, and a normal full write clears it.
- R7: Offsets 6 to 10 (window counters) are checked every cycle and raise stateUrgent. Either a normal full write or a trap-port write clears them.
- R8: Offset 11 (trap type) has no parity, and its flag is never set.
- R9: errClass reports 4 when fatalState is set. Otherwise it reports 3 for any state-urgent flag, 2 for a floating-point flag, 1 for an integer flag, and 0 when no flag is set.
- R10: After reset, all data is zero with good parity, all flags are clear, fatalState=0 and errClass=0.
- R11: When a clearing write and a detection hit the same register in the same cycle, the clear wins and the flag ends clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Instruction access valid |
| rdAddr | input | ADDR_W | Accessed register |
| rdData | output | DATA_W | Data of the accessed register |
| wrEn | input | 1 | Normal write request |
| wrFull | input | 1 | 1 = full write, 0 = low-half write |
| wrAddr | input | ADDR_W | Normal write target |
| wrData | input | DATA_W | Normal write data |
| fwMode | input | 1 | Normal write issued by firmware |
| trapWrEn | input | 1 | Trap-sequence full write |
| trapAddr | input | ADDR_W | Trap write target |
| trapData | input | DATA_W | Trap write data |
| redMode | input | 1 | Reset/recovery mode bit |
| intEnable | input | 1 | Interrupt enable mode bit |
| upsetEn | input | 1 | Flip one stored bit |
| upsetAddr | input | ADDR_W | Register to upset |
| upsetBit | input | BIT_W | Bit to flip |
| errFlags | output | NUM_REGS | Sticky per-register error flags |
| intUrgent | output | 1 | Integer register error present |
| fpUrgent | output | 1 | Floating-point register error present |
| stateUrgent | output | 1 | State register error present |
| fatalState | output | 1 | Fatal error state, sticky to reset |
| errClass | output | 3 | Priority-encoded class code |

## Verification
Two functions can meet in one cycle. The first is detection against a clearing write on the same register. The bench corrupts a register and then, in the very next cycle, issues the full write while the mismatch is visible or the access is active. The flag must end clear. The second is a fatal detection together with a state-urgent detection. The bench corrupts the trap base under redMode=1 and the program counter afterwards, then drops redMode so that both detections land on one edge. errClass must then read 4 while stateUrgent is also high.

// File: rtl/rpm_pkg.sv
`timescale 1ns/1ps
package rpm_pkg;

  localparam int OFF_PC      = 0;
  localparam int OFF_NPC     = 1;
  localparam int OFF_PSTATE  = 2;
  localparam int OFF_TBASE   = 3;
  localparam int OFF_TLEVEL  = 4;
  localparam int OFF_PIL     = 5;
  localparam int OFF_TTYPE   = 11;
  localparam int NUM_STATE   = 12;

  typedef enum logic [2:0] {
    K_GR, K_FR, K_CORE, K_GUARD, K_PRIO, K_WIN, K_BARE
  } regKind_e;

  typedef enum logic [2:0] {
    CLS_NONE = 3'd0, CLS_INT = 3'd1, CLS_FP = 3'd2, CLS_STATE = 3'd3, CLS_FATAL = 3'd4
  } errClass_e;

  typedef struct packed {
    logic normFull;
    logic normPart;
    logic trapFull;
    logic upset;
  } wrStrobes_t;

  function automatic regKind_e kindOf(input int idx, input int nGr, input int nFr);
    int off;
    regKind_e k;
    off = idx - nGr - nFr;
    if (idx < nGr)            k = K_GR;
    else if (idx < nGr + nFr) k = K_FR;
    else if (off <= OFF_PSTATE) k = K_CORE;
    else if (off <= OFF_TLEVEL) k = K_GUARD;
    else if (off == OFF_PIL)    k = K_PRIO;
    else if (off == OFF_TTYPE)  k = K_BARE;
    else                        k = K_WIN;
    return k;
  endfunction

endpackage

// File: rtl/rpm_datapath.sv
`timescale 1ns/1ps
module rpm_datapath #(
  parameter int NUM_GR = 8,
  parameter int NUM_FR = 8,
  parameter int DATA_W = 16,
  localparam int NUM_REGS = NUM_GR + NUM_FR + rpm_pkg::NUM_STATE,
  localparam int ADDR_W = $clog2(NUM_REGS + 1),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  rpm_pkg::wrStrobes_t stb,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   trapAddr,
  input  logic [DATA_W-1:0]   trapData,
  input  logic [ADDR_W-1:0]   upsetAddr,
  input  logic [BIT_W-1:0]    upsetBit,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic [NUM_REGS-1:0] mismVec
);
  import rpm_pkg::*;

  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] dataVec [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam regKind_e KIND = kindOf(i, NUM_GR, NUM_FR);
    localparam logic PROT = (KIND != K_BARE);

    logic [DATA_W-1:0] dataQ, dataN;
    logic              parQ, parN;
    logic              hitNorm, hitTrap, hitUpset;

    assign hitNorm  = (wrAddr == ADDR_W'(i));
    assign hitTrap  = (trapAddr == ADDR_W'(i));
    assign hitUpset = (upsetAddr == ADDR_W'(i));

    always_comb begin
      dataN = dataQ;
      parN  = parQ;
      if (stb.normFull && hitNorm) begin
        dataN = wrData;
        parN  = ^wrData;
      end else if (stb.normPart && hitNorm) begin
        dataN = {dataQ[DATA_W-1:HALF], wrData[HALF-1:0]};
        parN  = parQ ^ (^dataQ[HALF-1:0]) ^ (^wrData[HALF-1:0]);
      end
      if (stb.trapFull && hitTrap) begin
        dataN = trapData;
        parN  = ^trapData;
      end
      if (stb.upset && hitUpset) begin
        dataN = dataN ^ (DATA_W'(1) << upsetBit);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        dataQ <= '0;
        parQ  <= 1'b0;
      end else begin
        dataQ <= dataN;
        parQ  <= parN;
      end
    end

    assign dataVec[i] = dataQ;
    assign mismVec[i] = ((^dataQ) ^ parQ) & PROT;
  end

  always_comb begin
    rdData = '0;
    for (int j = 0; j < NUM_REGS; j++) begin
      if (rdAddr == ADDR_W'(j)) rdData = dataVec[j];
    end
  end

endmodule

// File: rtl/rpm_control.sv
`timescale 1ns/1ps
module rpm_control #(
  parameter int NUM_GR = 8,
  parameter int NUM_FR = 8,
  localparam int NUM_REGS = NUM_GR + NUM_FR + rpm_pkg::NUM_STATE,
  localparam int ADDR_W = $clog2(NUM_REGS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic                wrEn,
  input  logic                wrFull,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic                fwMode,
  input  logic                trapWrEn,
  input  logic [ADDR_W-1:0]   trapAddr,
  input  logic                upsetEn,
  input  logic [ADDR_W-1:0]   upsetAddr,
  input  logic                redMode,
  input  logic                intEnable,
  input  logic [NUM_REGS-1:0] mismVec,
  output rpm_pkg::wrStrobes_t stb,
  output logic [NUM_REGS-1:0] errFlags,
  output logic                intUrgent,
  output logic                fpUrgent,
  output logic                stateUrgent,
  output logic                fatalState,
  output logic [2:0]          errClass
);
  import rpm_pkg::*;

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_REGS - 1);

  logic wrOk, trapOk, upsetOk;
  assign wrOk    = (wrAddr <= LAST);
  assign trapOk  = (trapAddr <= LAST);
  assign upsetOk = (upsetAddr <= LAST);

  always_comb begin
    stb.normFull = wrEn & wrFull & wrOk;
    stb.normPart = wrEn & ~wrFull & wrOk;
    stb.trapFull = trapWrEn & trapOk;
    stb.upset    = upsetEn & upsetOk;
  end

  logic [NUM_REGS-1:0] setNow, grMask, frMask, stMask, guardMask;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_flag
    localparam regKind_e KIND = kindOf(i, NUM_GR, NUM_FR);

    logic accessHit, normHit, trapHit, checkNow, clearNow, flagQ;

    assign accessHit = rdEn && (rdAddr == ADDR_W'(i));
    assign normHit   = stb.normFull && (wrAddr == ADDR_W'(i));
    assign trapHit   = stb.trapFull && (trapAddr == ADDR_W'(i));

    always_comb begin
      case (KIND)
        K_GR, K_FR: begin checkNow = accessHit;             clearNow = normHit; end
        K_CORE:     begin checkNow = 1'b1;                  clearNow = trapHit; end
        K_GUARD:    begin checkNow = !redMode;              clearNow = normHit && fwMode; end
        K_PRIO:     begin checkNow = intEnable || accessHit; clearNow = normHit; end
        K_WIN:      begin checkNow = 1'b1;                  clearNow = normHit || trapHit; end
        default:    begin checkNow = 1'b0;                  clearNow = 1'b0; end
      endcase
    end

    assign setNow[i] = checkNow & mismVec[i] & ~clearNow;

    always_ff @(posedge clk) begin
      if (!rstN)         flagQ <= 1'b0;
      else if (clearNow) flagQ <= 1'b0;
      else if (setNow[i]) flagQ <= 1'b1;
    end

    assign errFlags[i]  = flagQ;
    assign grMask[i]    = (KIND == K_GR);
    assign frMask[i]    = (KIND == K_FR);
    assign stMask[i]    = (KIND == K_CORE) || (KIND == K_PRIO) || (KIND == K_WIN);
    assign guardMask[i] = (KIND == K_GUARD);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                    fatalState <= 1'b0;
    else if (|(setNow & guardMask)) fatalState <= 1'b1;
  end

  assign intUrgent   = |(errFlags & grMask);
  assign fpUrgent    = |(errFlags & frMask);
  assign stateUrgent = |(errFlags & stMask);

  errClass_e clsC;
  always_comb begin
    if (fatalState)       clsC = CLS_FATAL;
    else if (stateUrgent) clsC = CLS_STATE;
    else if (fpUrgent)    clsC = CLS_FP;
    else if (intUrgent)   clsC = CLS_INT;
    else                  clsC = CLS_NONE;
  end
  assign errClass = clsC;

endmodule

// File: rtl/parity_reg_monitor.sv
`timescale 1ns/1ps
module parity_reg_monitor #(
  parameter int NUM_GR = 8,
  parameter int NUM_FR = 8,
  parameter int DATA_W = 16,
  localparam int NUM_REGS = NUM_GR + NUM_FR + rpm_pkg::NUM_STATE,
  localparam int ADDR_W = $clog2(NUM_REGS + 1),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic                wrEn,
  input  logic                wrFull,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                fwMode,
  input  logic                trapWrEn,
  input  logic [ADDR_W-1:0]   trapAddr,
  input  logic [DATA_W-1:0]   trapData,
  input  logic                redMode,
  input  logic                intEnable,
  input  logic                upsetEn,
  input  logic [ADDR_W-1:0]   upsetAddr,
  input  logic [BIT_W-1:0]    upsetBit,
  output logic [NUM_REGS-1:0] errFlags,
  output logic                intUrgent,
  output logic                fpUrgent,
  output logic                stateUrgent,
  output logic                fatalState,
  output logic [2:0]          errClass
);

  rpm_pkg::wrStrobes_t stb;
  logic [NUM_REGS-1:0] mismVec;

  rpm_control #(.NUM_GR(NUM_GR), .NUM_FR(NUM_FR)) u_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
    .wrEn(wrEn), .wrFull(wrFull), .wrAddr(wrAddr), .fwMode(fwMode),
    .trapWrEn(trapWrEn), .trapAddr(trapAddr),
    .upsetEn(upsetEn), .upsetAddr(upsetAddr),
    .redMode(redMode), .intEnable(intEnable), .mismVec(mismVec),
    .stb(stb), .errFlags(errFlags), .intUrgent(intUrgent), .fpUrgent(fpUrgent),
    .stateUrgent(stateUrgent), .fatalState(fatalState), .errClass(errClass)
  );

  rpm_datapath #(.NUM_GR(NUM_GR), .NUM_FR(NUM_FR), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData), .trapAddr(trapAddr), .trapData(trapData),
    .upsetAddr(upsetAddr), .upsetBit(upsetBit),
    .rdAddr(rdAddr), .rdData(rdData), .mismVec(mismVec)
  );

endmodule

// File: rtl/rpm_checker.sv
`timescale 1ns/1ps
module rpm_checker #(
  parameter int NUM_GR = 8,
  parameter int NUM_FR = 8,
  localparam int NUM_REGS = NUM_GR + NUM_FR + rpm_pkg::NUM_STATE,
  localparam int ADDR_W = $clog2(NUM_REGS + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic                rdEn,
  input logic [ADDR_W-1:0]   rdAddr,
  input logic                wrEn,
  input logic                wrFull,
  input logic [ADDR_W-1:0]   wrAddr,
  input logic                trapWrEn,
  input logic [ADDR_W-1:0]   trapAddr,
  input logic [NUM_REGS-1:0] errFlags,
  input logic                fatalState,
  input logic [2:0]          errClass
);
  localparam int PC_IDX = NUM_GR + NUM_FR + rpm_pkg::OFF_PC;
  localparam int TT_IDX = NUM_GR + NUM_FR + rpm_pkg::OFF_TTYPE;
  localparam logic [ADDR_W-1:0] PC_A = ADDR_W'(PC_IDX);

  a_r5_fatal_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fatalState |=> fatalState);

  a_r8_ttype_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !errFlags[TT_IDX]);

  a_r4_normal_write_keeps: assert property (@(posedge clk) disable iff (!rstN)
    errFlags[PC_IDX] && !(trapWrEn && trapAddr == PC_A) |=> errFlags[PC_IDX]);

  a_r4_trap_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    trapWrEn && trapAddr == PC_A |=> !errFlags[PC_IDX]);

  a_r2_access_needed: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlags[0]) |-> $past(rdEn && rdAddr == '0));

  a_r3_full_write_clears: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrFull && wrAddr < ADDR_W'(NUM_GR) |=> !errFlags[$past(wrAddr)]);

  a_r9_fatal_class: assert property (@(posedge clk) disable iff (!rstN)
    fatalState |-> errClass == 3'd4);

endmodule

bind parity_reg_monitor rpm_checker #(.NUM_GR(NUM_GR), .NUM_FR(NUM_FR)) u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr),
  .wrEn(wrEn), .wrFull(wrFull), .wrAddr(wrAddr),
  .trapWrEn(trapWrEn), .trapAddr(trapAddr),
  .errFlags(errFlags), .fatalState(fatalState), .errClass(errClass)
);

// File: tb/sim_parity_reg_monitor.sv
`timescale 1ns/1ps
module sim_parity_reg_monitor;
  localparam int NG = 8, NF = 8, DW = 16, NR = NG + NF + 12, AW = 5, BW = 4;
  localparam int PC = NG + NF, TB = PC + 3, PIL = PC + 5, W0 = PC + 6, TT = PC + 11;

  logic clk = 1'b0, rstN = 1'b0;
  logic rdEn, wrEn, wrFull, fwMode, trapWrEn, redMode, intEnable, upsetEn;
  logic [AW-1:0] rdAddr, wrAddr, trapAddr, upsetAddr;
  logic [DW-1:0] wrData, trapData, rdData;
  logic [BW-1:0] upsetBit;
  logic [NR-1:0] errFlags;
  logic intUrgent, fpUrgent, stateUrgent, fatalState;
  logic [2:0] errClass;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  parity_reg_monitor #(.NUM_GR(NG), .NUM_FR(NF), .DATA_W(DW)) u0 (.*);

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idleIns();
    rdEn = 0; wrEn = 0; wrFull = 0; fwMode = 0; trapWrEn = 0; upsetEn = 0;
    rdAddr = '0; wrAddr = '0; trapAddr = '0; upsetAddr = '0;
    wrData = '0; trapData = '0; upsetBit = '0;
  endtask

  task automatic doWrite(input int a, input logic [DW-1:0] d, input logic full, input logic fw);
    wrEn = 1; wrAddr = AW'(a); wrData = d; wrFull = full; fwMode = fw;
    tick(); idleIns();
  endtask

  task automatic doTrap(input int a, input logic [DW-1:0] d);
    trapWrEn = 1; trapAddr = AW'(a); trapData = d;
    tick(); idleIns();
  endtask

  task automatic doUpset(input int a, input int b);
    upsetEn = 1; upsetAddr = AW'(a); upsetBit = BW'(b);
    tick(); idleIns();
  endtask

  task automatic doRead(input int a, output logic [DW-1:0] v);
    rdEn = 1; rdAddr = AW'(a); #1 v = rdData;
    tick(); idleIns();
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk("R10 flags", errFlags, 0);
    chk("R10 fatal", fatalState, 0);
    chk("R10 class", errClass, 0);
    doRead(3, v);
    chk("R10 data zero", v, 0);
    chk("R10 no flag on good parity", errFlags, 0);
  endtask

  task automatic t_readWrite();
    logic [DW-1:0] v;
    doWrite(3, 16'hA5C3, 1, 0);
    doRead(3, v);
    chk("R1 full write readback", v, 16'hA5C3);
    doWrite(3, 16'hFF11, 0, 0);
    doRead(3, v);
    chk("R1 partial write low half", v, 16'hA511);
    chk("R1 no false error", errFlags, 0);
  endtask

  task automatic t_general();
    logic [DW-1:0] v;
    doUpset(2, 5); tick(); tick();
    chk("R2 unread not flagged", errFlags[2], 0);
    doRead(2, v);
    chk("R2 read flags", errFlags[2], 1);
    chk("R2 intUrgent", intUrgent, 1);
    chk("R9 int class", errClass, 1);
    doWrite(2, 16'h00FF, 0, 0);
    chk("R3 partial keeps flag", errFlags[2], 1);
    doRead(2, v);
    chk("R3 still flagged", errFlags[2], 1);
    doWrite(2, 16'h1234, 1, 0);
    chk("R3 full write clears", errFlags[2], 0);
    chk("R3 intUrgent low", intUrgent, 0);
  endtask

  task automatic t_float();
    logic [DW-1:0] v;
    doUpset(1, 0); doRead(1, v);
    doUpset(NG + 1, 9); doRead(NG + 1, v);
    chk("R2 fp flag", errFlags[NG + 1], 1);
    chk("R2 fpUrgent", fpUrgent, 1);
    chk("R9 fp over int", errClass, 2);
    doWrite(1, 16'h0, 1, 0);
    doWrite(NG + 1, 16'h0, 1, 0);
    chk("R3 fp cleared", errFlags, 0);
    chk("R9 class none", errClass, 0);
  endtask

  task automatic t_core();
    logic [DW-1:0] v;
    doUpset(PC, 2); tick();
    chk("R4 always checked", errFlags[PC], 1);
    chk("R4 stateUrgent", stateUrgent, 1);
    chk("R9 state class", errClass, 3);
    doWrite(PC, 16'h0040, 1, 0);
    chk("R4 normal write keeps", errFlags[PC], 1);
    doTrap(PC, 16'h0080);
    chk("R4 trap write clears", errFlags[PC], 0);
    doRead(PC, v);
    chk("R4 trap data stored", v, 16'h0080);
  endtask

  task automatic t_window();
    doUpset(W0 + 1, 7); tick();
    chk("R7 window detect", errFlags[W0 + 1], 1);
    doWrite(W0 + 1, 16'h3, 1, 0);
    chk("R7 normal clears", errFlags[W0 + 1], 0);
    doUpset(W0 + 3, 0); tick();
    chk("R7 second detect", stateUrgent, 1);
    doTrap(W0 + 3, 16'h2);
    chk("R7 trap clears", errFlags[W0 + 3], 0);
  endtask

  task automatic t_pil();
    logic [DW-1:0] v;
    intEnable = 0;
    doUpset(PIL, 4); tick(); tick();
    chk("R6 masked when ie=0", errFlags[PIL], 0);
    intEnable = 1; tick();
    chk("R6 ie=1 detects", errFlags[PIL], 1);
    intEnable = 0;
    doWrite(PIL, 16'h5, 1, 0);
    chk("R6 write clears", errFlags[PIL], 0);
    doUpset(PIL, 1); doRead(PIL, v);
    chk("R6 access detects", errFlags[PIL], 1);
    doWrite(PIL, 16'h5, 1, 0);
    chk("R6 cleared again", stateUrgent, 0);
  endtask

  task automatic t_ttype();
    logic [DW-1:0] v;
    doUpset(TT, 0); tick(); doRead(TT, v);
    chk("R8 ttype silent", errFlags[TT], 0);
    chk("R8 class unchanged", errClass, 0);
  endtask

  task automatic t_sameCycle();
    logic [DW-1:0] v;
    doUpset(4, 6);
    rdEn = 1; rdAddr = AW'(4);
    wrEn = 1; wrFull = 1; wrAddr = AW'(4); wrData = 16'h0F0F;
    tick(); idleIns();
    chk("R11 access vs clear", errFlags[4], 0);
    doRead(4, v);
    chk("R11 data written", v, 16'h0F0F);
    chk("R11 no later flag", errFlags[4], 0);
    doUpset(W0, 3);
    doWrite(W0, 16'h7, 1, 0);
    chk("R11 window clear wins", errFlags[W0], 0);
  endtask

  task automatic t_fatal();
    redMode = 1;
    doUpset(TB, 3); tick(); tick();
    chk("R5 masked under red", errFlags[TB], 0);
    chk("R5 no fatal under red", fatalState, 0);
    doUpset(PC, 0);
    redMode = 0; tick();
    chk("R5 guard detect", errFlags[TB], 1);
    chk("R5 fatal set", fatalState, 1);
    chk("R9 state also set", stateUrgent, 1);
    chk("R9 fatal wins", errClass, 4);
    doWrite(TB, 16'h1234, 1, 0);
    chk("R5 non-fw write keeps", errFlags[TB], 1);
    doWrite(TB, 16'h1234, 1, 1);
    chk("R5 fw write clears", errFlags[TB], 0);
    chk("R5 fatal sticky", fatalState, 1);
    doTrap(PC, 16'h0100);
    chk("R9 fatal still reported", errClass, 4);
    doUpset(TB + 1, 2); tick();
    chk("R5 trap level detect", errFlags[TB + 1], 1);
  endtask

  initial begin
    idleIns(); redMode = 0; intEnable = 0;
    tick(); tick(); tick();
    rstN = 1; tick();
    t_reset(); t_readWrite(); t_general(); t_float(); t_core();
    t_window(); t_pil(); t_ttype(); t_sameCycle(); t_fatal();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule